// File: doc/BRIEF.md
# Bit-Slice Sum-of-Products Pattern Matcher

This block watches eight input signals and evaluates a programmable sum-of-products expression over them. Eight slices sit in a chain. Each slice picks one of the eight inputs and tests it against one of eight conditions: a level, a non-latching edge, a latching edge, or a constant true or false. A slice can also be marked as the end of a product term. A product term is the AND of every slice from just after the previous end slice up to and including its own end slice. The last slice always closes a term.

Every term that holds drives a match bit at the position of its end slice. A one-cycle event pulse can be raised when the OR of all terms goes from false to true. Software reaches the block through a small register port. Through it, software programs the input sources, the conditions and the term boundaries, turns the matcher and the event pulse on and off one at a time, reads back the match status, and re-arms the latching edge conditions.

A three-state controller runs the matcher. OFF means the matcher is disabled and every output is held low. WATCH means it is enabled and no term holds. HIT means at least one term holds. The controller moves OFF->WATCH or OFF->HIT when the matcher is enabled, WATCH->HIT when a term starts to hold, HIT->WATCH when the last holding term drops, and from any state to OFF when the matcher is disabled. The event pulse fires on each entry into HIT while the event enable is set.

Top module: `patmatch_engine`

## Requirements
- R1: After reset, term_match and rx_event are 0. Reads of register 3 return 0. Reads of register 2 return 0x80, because slice 7 is always an end slice.
- R2: Register 0 holds the input source of slice i in bits [3i+2:3i]. Inputs pass through a two-stage synchronizer. A pin level set before a rising clock edge can change term_match only after the third rising edge, counting that edge.
- R3: Register 1 holds the condition code of slice i in bits [3i+2:3i]. Code 0 is always true, code 4 is true while the input is high, code 5 is true while the input is low, and code 6 is never true.
- R4: Codes 1 (rising), 2 (falling) and 3 (either edge) latch. Once the edge is seen, the slice stays true until its latched state is cleared.
- R5: Code 7 is true only in the single cycle in which an edge of either direction is seen. It does not latch.
- R6: Register 2 bit i marks slice i as an end slice. Slice 7 always ends a term. term_match[i] is 1 only when slice i is an end slice and all slices of its term are true.
- R7: Writing register 3 with 1s sets the matching control bits. Writing register 4 with 1s clears them. Bit 0 is the matcher enable and bit 1 is the event enable, and changing one leaves the other unchanged. While the matcher enable is 0, term_match and rx_event stay 0.
- R8: rx_event is a one-cycle pulse. It is raised in the same cycle as term_match goes from all-zero to non-zero, and only if the event enable is set.
- R9: Writing register 3 with bit 2 set clears the latched state of every slice. Any write to register 0 or register 1 also clears it.
- R10: Reads of register 3 or register 4 return term_match in bits [31:24], the event enable in bit 1 and the matcher enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Asynchronous signals under watch |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| term_match | output | 8 | Per-end-slice term match, registered |
| rx_event | output | 1 | One-cycle pulse when any term starts to hold |

## Verification
The hardest situation to reach from the ports is a latched edge that must survive many cycles after its input has returned to its resting level, then be cleared by the re-arm command, and then latch again on a fresh edge. A second hard situation is the same latch being dropped by a reconfiguration write that lands while a term is holding. Directed sequences pulse one pin, wait, re-arm and pulse again. The random phase mixes pin toggles with writes to the condition, source and control registers, including re-arm commands, in the same cycles in which edges arrive. A bench reference model predicts every cycle of term_match and rx_event.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        C_ALWAYS   = 3'd0,
        C_STK_RISE = 3'd1,
        C_STK_FALL = 3'd2,
        C_STK_ANY  = 3'd3,
        C_HIGH     = 3'd4,
        C_LOW      = 3'd5,
        C_NEVER    = 3'd6,
        C_EDGE     = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_HIT   = 2'd2
    } fsm_e;

    localparam logic [2:0] A_SRC  = 3'd0;
    localparam logic [2:0] A_COND = 3'd1;
    localparam logic [2:0] A_ENDP = 3'd2;
    localparam logic [2:0] A_CSET = 3'd3;
    localparam logic [2:0] A_CCLR = 3'd4;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            stage1 <= raw;
            cur    <= stage1;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/pm_slice.sv
module pm_slice #(
    parameter int NIN = 8,
    parameter int SW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] cur,
    input  logic [NIN-1:0] prev,
    input  logic [SW-1:0]  sel,
    input  pm_pkg::cond_e  cond,
    input  logic           clr,
    output logic           ok
);
    import pm_pkg::*;

    logic now_v, was_v, rise, fall, catch_v, sticky_q;

    assign now_v = cur[sel];
    assign was_v = prev[sel];
    assign rise  = now_v & ~was_v;
    assign fall  = ~now_v & was_v;

    always_comb begin
        unique case (cond)
            C_STK_RISE: catch_v = rise;
            C_STK_FALL: catch_v = fall;
            C_STK_ANY:  catch_v = rise | fall;
            default:    catch_v = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sticky_q <= 1'b0;
        else if (clr) sticky_q <= 1'b0;
        else          sticky_q <= sticky_q | catch_v;
    end

    always_comb begin
        unique case (cond)
            C_ALWAYS:   ok = 1'b1;
            C_STK_RISE,
            C_STK_FALL,
            C_STK_ANY:  ok = sticky_q | catch_v;
            C_HIGH:     ok = now_v;
            C_LOW:      ok = ~now_v;
            C_NEVER:    ok = 1'b0;
            C_EDGE:     ok = rise | fall;
            default:    ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pm_regs.sv
module pm_regs #(
    parameter int NSLICE = 8,
    parameter int SW     = 3,
    parameter int DW     = 32,
    parameter int AW     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    input  logic [NSLICE-1:0]           match_st,
    output logic [NSLICE*SW-1:0]        src_flat,
    output logic [NSLICE*pm_pkg::COND_W-1:0] cond_flat,
    output logic [NSLICE-1:0]           endp_eff,
    output logic                        mode_q,
    output logic                        ev_en_q,
    output logic                        clr_sticky
);
    import pm_pkg::*;

    localparam int SRC_BITS  = NSLICE * SW;
    localparam int COND_BITS = NSLICE * COND_W;

    logic [NSLICE-1:0] endp_q;
    logic hit_src, hit_cond, hit_endp, hit_set, hit_clr;

    assign hit_src  = we && (addr == AW'(A_SRC));
    assign hit_cond = we && (addr == AW'(A_COND));
    assign hit_endp = we && (addr == AW'(A_ENDP));
    assign hit_set  = we && (addr == AW'(A_CSET));
    assign hit_clr  = we && (addr == AW'(A_CCLR));

    assign clr_sticky = hit_src | hit_cond | (hit_set & wdata[2]);
    assign endp_eff   = {1'b1, endp_q[NSLICE-2:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_flat  <= '0;
            cond_flat <= '0;
            endp_q    <= '0;
            mode_q    <= 1'b0;
            ev_en_q   <= 1'b0;
        end else begin
            if (hit_src)  src_flat  <= wdata[SRC_BITS-1:0];
            if (hit_cond) cond_flat <= wdata[COND_BITS-1:0];
            if (hit_endp) endp_q    <= wdata[NSLICE-1:0];
            if (hit_set) begin
                mode_q  <= mode_q  | wdata[0];
                ev_en_q <= ev_en_q | wdata[1];
            end else if (hit_clr) begin
                mode_q  <= mode_q  & ~wdata[0];
                ev_en_q <= ev_en_q & ~wdata[1];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(A_SRC)) begin
            rdata[SRC_BITS-1:0] = src_flat;
        end else if (addr == AW'(A_COND)) begin
            rdata[COND_BITS-1:0] = cond_flat;
        end else if (addr == AW'(A_ENDP)) begin
            rdata[NSLICE-1:0] = endp_eff;
        end else if (addr == AW'(A_CSET) || addr == AW'(A_CCLR)) begin
            rdata[0]             = mode_q;
            rdata[1]             = ev_en_q;
            rdata[DW-1 -: NSLICE] = match_st;
        end
    end
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm #(
    parameter int NSLICE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_q,
    input  logic              ev_en_q,
    input  logic [NSLICE-1:0] term_d,
    output logic [NSLICE-1:0] term_match,
    output logic              rx_event,
    output pm_pkg::fsm_e      state_q
);
    import pm_pkg::*;

    fsm_e state_d;
    logic any_d;

    assign any_d = |term_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_OFF;
        unique case (state_q)
            ST_OFF:   state_d = !mode_q ? ST_OFF : (any_d ? ST_HIT : ST_WATCH);
            ST_WATCH: state_d = !mode_q ? ST_OFF : (any_d ? ST_HIT : ST_WATCH);
            ST_HIT:   state_d = !mode_q ? ST_OFF : (any_d ? ST_HIT : ST_WATCH);
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_match <= '0;
            rx_event   <= 1'b0;
        end else begin
            term_match <= mode_q ? term_d : '0;
            rx_event   <= mode_q && ev_en_q && any_d && (state_q != ST_HIT);
        end
    end
endmodule

// File: rtl/patmatch_engine.sv
module patmatch_engine #(
    parameter int NSLICE = 8,
    parameter int NIN    = 8,
    parameter int DW     = 32,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIN-1:0]    pin_in,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NSLICE-1:0] term_match,
    output logic              rx_event
);
    import pm_pkg::*;

    localparam int SW = (NIN > 1) ? $clog2(NIN) : 1;

    logic [NIN-1:0]             cur, prev;
    logic [NSLICE*SW-1:0]       src_flat;
    logic [NSLICE*COND_W-1:0]   cond_flat;
    logic [NSLICE-1:0]          endp_eff, ok, acc, term_d;
    logic                       mode_q, ev_en_q, clr_sticky;
    fsm_e                       state_q;

    pm_sync #(.W(NIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(cur), .prev(prev)
    );

    pm_regs #(.NSLICE(NSLICE), .SW(SW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .match_st(term_match),
        .src_flat(src_flat), .cond_flat(cond_flat), .endp_eff(endp_eff),
        .mode_q(mode_q), .ev_en_q(ev_en_q), .clr_sticky(clr_sticky)
    );

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        pm_slice #(.NIN(NIN), .SW(SW)) u_slice (
            .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev),
            .sel(src_flat[SW*i +: SW]),
            .cond(cond_e'(cond_flat[COND_W*i +: COND_W])),
            .clr(clr_sticky), .ok(ok[i])
        );
        if (i == 0) begin : g_head
            assign acc[i] = ok[i];
        end else begin : g_link
            assign acc[i] = ok[i] & (endp_eff[i-1] | acc[i-1]);
        end
        assign term_d[i] = endp_eff[i] & acc[i];
    end

    pm_fsm #(.NSLICE(NSLICE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .ev_en_q(ev_en_q),
        .term_d(term_d), .term_match(term_match), .rx_event(rx_event),
        .state_q(state_q)
    );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int NSLICE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSLICE-1:0] term_match,
    input logic              rx_event,
    input logic              mode_q,
    input logic              ev_en_q,
    input logic [NSLICE-1:0] endp_eff
);
    // R8: a pulse only comes with a holding term
    a_r8_event_with_match: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> (term_match != '0));

    // R8: the pulse lasts one cycle
    a_r8_event_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> !rx_event);

    // R8: no pulse unless the event enable was set
    a_r8_event_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_en_q |=> !rx_event);

    // R7: disabled matcher keeps outputs low
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |=> (term_match == '0) && !rx_event);

    // R6: only end slices report a match
    a_r6_only_endpoints: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((term_match & ~$past(endp_eff)) == '0));

    // R6: last slice always closes a term
    a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        endp_eff[NSLICE-1]);
endmodule

bind patmatch_engine pm_checker #(.NSLICE(NSLICE)) u_chk (
    .clk(clk), .rst_n(rst_n), .term_match(term_match), .rx_event(rx_event),
    .mode_q(mode_q), .ev_en_q(ev_en_q), .endp_eff(endp_eff)
);

// File: tb/patmatch_engine_bench.sv
module patmatch_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  term_match;
    logic        rx_event;

    int checks = 0;
    int failures = 0;
    bit checking = 0;
    bit done = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    patmatch_engine u_patmatch_engine (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .term_match(term_match), .rx_event(rx_event)
    );

    // reference model state
    logic [7:0] m_s1, m_cur, m_prev, m_endp, m_sticky, m_match;
    logic [2:0] m_src [8];
    logic [2:0] m_cond[8];
    logic       m_mode, m_ev, m_evt;

    function automatic logic [7:0] model_catch();
        logic [7:0] c;
        for (int i = 0; i < 8; i++) begin
            logic p, q;
            p = m_cur[m_src[i]];
            q = m_prev[m_src[i]];
            case (m_cond[i])
                3'd1: c[i] = p & ~q;
                3'd2: c[i] = ~p & q;
                3'd3: c[i] = p ^ q;
                default: c[i] = 1'b0;
            endcase
        end
        return c;
    endfunction

    function automatic logic [7:0] model_ok();
        logic [7:0] r, c;
        c = model_catch();
        for (int i = 0; i < 8; i++) begin
            logic p, q;
            p = m_cur[m_src[i]];
            q = m_prev[m_src[i]];
            case (m_cond[i])
                3'd0: r[i] = 1'b1;
                3'd1, 3'd2, 3'd3: r[i] = m_sticky[i] | c[i];
                3'd4: r[i] = p;
                3'd5: r[i] = ~p;
                3'd6: r[i] = 1'b0;
                default: r[i] = p ^ q;
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] model_terms(input logic [7:0] ok);
        logic [7:0] t;
        logic run;
        t = '0;
        run = 1'b1;
        for (int i = 0; i < 8; i++) begin
            run = run & ok[i];
            if (m_endp[i] || i == 7) begin
                t[i] = run;
                run = 1'b1;
            end
        end
        return t;
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            3'd0: for (int i = 0; i < 8; i++) r[3*i +: 3] = m_src[i];
            3'd1: for (int i = 0; i < 8; i++) r[3*i +: 3] = m_cond[i];
            3'd2: r[7:0] = m_endp | 8'h80;
            3'd3, 3'd4: r = {m_match, 22'd0, m_ev, m_mode};
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_cur = '0; m_prev = '0; m_endp = '0;
            m_sticky = '0; m_match = '0; m_mode = 0; m_ev = 0; m_evt = 0;
            for (int i = 0; i < 8; i++) begin m_src[i] = '0; m_cond[i] = '0; end
        end else begin
            logic [7:0] t, c, nm;
            logic ne, clr;
            t  = model_terms(model_ok());
            c  = model_catch();
            nm = m_mode ? t : 8'h00;
            ne = m_mode & m_ev & (|t) & ~(|m_match);
            clr = reg_we && (reg_addr == 3'd0 || reg_addr == 3'd1 ||
                             (reg_addr == 3'd3 && reg_wdata[2]));
            m_sticky = clr ? 8'h00 : (m_sticky | c);
            if (reg_we) begin
                case (reg_addr)
                    3'd0: for (int i = 0; i < 8; i++) m_src[i]  = reg_wdata[3*i +: 3];
                    3'd1: for (int i = 0; i < 8; i++) m_cond[i] = reg_wdata[3*i +: 3];
                    3'd2: m_endp = reg_wdata[7:0];
                    3'd3: begin m_mode = m_mode | reg_wdata[0]; m_ev = m_ev | reg_wdata[1]; end
                    3'd4: begin m_mode = m_mode & ~reg_wdata[0]; m_ev = m_ev & ~reg_wdata[1]; end
                    default: ;
                endcase
            end
            m_prev = m_cur;
            m_cur  = m_s1;
            m_s1   = pin_in;
            m_match = nm;
            m_evt   = ne;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%08h exp=0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking && rst_n) begin
            chk({cur_tag, " term_match"}, 32'(term_match), 32'(m_match));
            chk({cur_tag, " rx_event"}, 32'(rx_event), 32'(m_evt));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk({tag, " read"}, reg_rdata, model_read(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    function automatic logic [31:0] pack3(input logic [2:0] a0, input logic [2:0] rest);
        logic [31:0] r;
        r = '0;
        r[2:0] = a0;
        for (int i = 1; i < 8; i++) r[3*i +: 3] = rest;
        return r;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'h5EED_1234));
        idle(3);
        rst_n = 1'b1;
        checking = 1;

        // R1 reset state
        cur_tag = "R1";
        rd(3'd3, "R1");
        chk("R1 ctrl zero", reg_rdata, 32'h0);
        rd(3'd2, "R1");
        chk("R1 endp slice7", reg_rdata, 32'h80);

        // R3 level on pin2 through slice0, other slices never
        cur_tag = "R3";
        wr(3'd0, pack3(3'd2, 3'd0));
        wr(3'd1, pack3(3'd4, 3'd6));
        wr(3'd2, 32'h01);
        wr(3'd3, 32'h1);
        setpins(8'h04);
        // R2 latency: not yet after two edges, visible after three
        @(posedge clk); @(posedge clk); #1;
        chk("R2 latency early", 32'(term_match), 32'h0);
        @(posedge clk); #1;
        chk("R2 latency visible", 32'(term_match), 32'h1);
        rd(3'd0, "R2");
        wr(3'd1, pack3(3'd5, 3'd6));
        idle(4);
        chk("R3 low on high pin", 32'(term_match), 32'h0);
        setpins(8'h00);
        idle(4);
        chk("R3 low on low pin", 32'(term_match), 32'h1);
        wr(3'd1, pack3(3'd0, 3'd6));
        idle(2);
        chk("R3 always", 32'(term_match), 32'h1);

        // R4 sticky rising on pin1
        cur_tag = "R4";
        wr(3'd0, pack3(3'd1, 3'd0));
        wr(3'd1, pack3(3'd1, 3'd6));
        setpins(8'h02);
        setpins(8'h00);
        idle(8);
        chk("R4 sticky holds", 32'(term_match), 32'h1);

        // R9 re-arm command clears, fresh edge latches again
        cur_tag = "R9";
        wr(3'd3, 32'h5);
        idle(2);
        chk("R9 cleared by rearm", 32'(term_match), 32'h0);
        setpins(8'h02);
        idle(5);
        chk("R9 relatched", 32'(term_match), 32'h1);
        wr(3'd1, pack3(3'd2, 3'd6));
        idle(2);
        chk("R9 cleared by cfg write", 32'(term_match), 32'h0);
        setpins(8'h00);
        idle(5);
        chk("R4 sticky fall", 32'(term_match), 32'h1);

        // R5 non-latching edge: exactly one cycle per edge
        cur_tag = "R5";
        wr(3'd1, pack3(3'd7, 3'd6));
        idle(3);
        setpins(8'h02);
        pulses = 0;
        repeat (8) begin @(negedge clk); if (term_match[0]) pulses++; end
        chk("R5 one cycle", 32'(pulses), 32'd1);

        // R6 terms: slices0,1 high on pins0,1 end at 1; 2..7 always
        cur_tag = "R6";
        wr(3'd0, 32'h0000_0008);
        wr(3'd1, 32'h0000_0024);
        wr(3'd2, 32'h02);
        setpins(8'h01);
        idle(4);
        chk("R6 partial term", 32'(term_match), 32'h80);
        setpins(8'h03);
        idle(4);
        chk("R6 both terms", 32'(term_match), 32'h82);

        // R10 status readback
        cur_tag = "R10";
        rd(3'd3, "R10");
        chk("R10 status bits", reg_rdata, 32'h8200_0001);

        // R7 independent set/clear, disable holds outputs low
        cur_tag = "R7";
        wr(3'd3, 32'h2);
        wr(3'd4, 32'h1);
        idle(2);
        chk("R7 off quiet", 32'(term_match), 32'h0);
        rd(3'd4, "R7");
        chk("R7 event enable kept", reg_rdata, 32'h2);

        // R8 event pulse on re-enable with terms holding
        cur_tag = "R8";
        wr(3'd3, 32'h1);
        pulses = 0;
        repeat (6) begin @(negedge clk); if (rx_event) pulses++; end
        chk("R8 single pulse", 32'(pulses), 32'd1);
        wr(3'd4, 32'h2);
        setpins(8'h00);
        idle(4);
        setpins(8'h03);
        pulses = 0;
        repeat (6) begin @(negedge clk); if (rx_event) pulses++; end
        chk("R8 no pulse when disabled", 32'(pulses), 32'd0);
        wr(3'd3, 32'h2);

        // random mix checked against the model each cycle
        cur_tag = "R6 random";
        for (int n = 0; n < 3000; n++) begin
            int k;
            k = $urandom_range(0, 19);
            if (k == 0) wr(3'd0, $urandom);
            else if (k == 1) wr(3'd1, $urandom);
            else if (k == 2) wr(3'd2, $urandom);
            else if (k == 3) wr(3'd3, $urandom & 32'h7);
            else if (k == 4) wr(3'd4, $urandom & 32'h3);
            else if (k == 5) rd(3'($urandom_range(0, 7)), "R10 random");
            else setpins(($urandom_range(0, 3) == 0) ? 8'($urandom) : pin_in);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule